// File: doc/BRIEF.md
# Nearest-Frequency PLL Setting Search Engine

This block searches every setting of a programmable clock synthesiser for the one whose output comes closest to a requested frequency. The synthesiser takes a fixed reference clock, multiplies it by M, divides it by N and may halve it (post-shift K). An output stage then divides that source by an odd divider and a binary shift. The engine walks the whole space one candidate at a time. For each candidate it works out the rounded output frequency and its distance from the request, and it keeps the first candidate with the smallest distance.

The caller asks for twice the wanted pixel frequency. When the sweep ends the engine reports the chosen M, N, K, odd divider and shift, the achieved frequency (halved to match the caller's doubling), and a packed control word for the synthesiser. All arithmetic goes through one shared restoring divider that produces one quotient bit per cycle. The divide of the reference product by N is done once per (M, N) pair and is reused for both K values.

Top module: `pllsrch_engine`

## Requirements
- R1: After reset, busy and done are 0, achieved_freq is 0, every chosen field is 0 and pll_word reads 0x00020000.
- R2: The source frequency is floor(REF_HZ*M/N) shifted right by K (REF_HZ defaults to 24,000,000). A candidate's output is floor((src + d/2)/d) with d = div << shift, and its error is |output - req_freq|. The chosen setting has the smallest error over the whole space.
- R3: M runs from M_MIN to M_MAX (defaults 2 and 255), N from N_MIN to N_MAX (defaults 2 and 127), K over 0 and 1. The odd divider takes 1, 3, 5 ... up to max_div, and shift runs from 0 to 7.
- R4: The candidate order is M outermost, then N, K, divider, with shift innermost. The best setting is replaced only by a strictly smaller error, so the earliest candidate wins a tie.
- R5: The best error starts at 999,999,999 on every start. If no candidate improves on it, the chosen fields stay 0 and achieved_freq reads 0.
- R6: pll_word = 0x00020000 | (K << 15) | (N << 8) | M, with M in bits 7:0, N in bits 14:8, K in bit 15 and bit 17 set.
- R7: achieved_freq = floor(best_src / (2 * (div << shift))).
- R8: A start seen while idle makes busy 1 on the next cycle. done is a single-cycle pulse, and busy is 0 while done is 1. A start pulse seen while busy has no effect on the result.
- R9: req_freq and max_div are captured at the accepted start. Changes to them during the sweep do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a search (accepted only when idle) |
| req_freq | input | FW (32) | Requested frequency in Hz, already doubled by the caller |
| max_div | input | 3 | Largest odd output divider to try (3 or 5 in use) |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle pulse when the result is valid |
| m_out | output | 8 | Chosen multiplier M |
| n_out | output | 7 | Chosen divider N |
| k_out | output | 1 | Chosen post-shift K |
| div_out | output | 3 | Chosen odd output divider |
| shift_out | output | SH_W (3) | Chosen binary output shift |
| achieved_freq | output | FW (32) | Achieved frequency, halved |
| pll_word | output | 32 | Packed synthesiser control word |

## Verification
A wrong sweep index or comparison inside the engine stays hidden until done rises. It then shows as a wrong M, N, K, divider or shift, and as a pll_word and achieved_freq that disagree with the arithmetic optimum, because the bench recomputes the full search for each request. A broken handshake, such as a missing busy, a done longer than one cycle, or a restart taken mid-sweep, shows at the ports within a cycle of the event, or as a wrong result at the end of that search. A damaged error initialisation shows on a request that no candidate can approach: there the fields must stay 0.

// File: rtl/pllsrch_pkg.sv
package pllsrch_pkg;

  localparam int M_W  = 8;
  localparam int N_W  = 7;
  localparam int DV_W = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SRC,
    ST_SRCW,
    ST_CAND,
    ST_CANDW,
    ST_FIN,
    ST_FINW
  } phase_t;

  // Control word layout: M[7:0], N[14:8], K[15], enable bit 17.
  function automatic logic [31:0] pack_word(input logic k,
                                            input logic [N_W-1:0] n,
                                            input logic [M_W-1:0] m);
    pack_word = 32'h0002_0000 | (32'(k) << 15) | (32'(n) << 8) | 32'(m);
  endfunction

endpackage

// File: rtl/pllsrch_rst_sync.sv
module pllsrch_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/pllsrch_div.sv
module pllsrch_div #(
  parameter int NW = 34,
  parameter int DW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          done,
  output logic [NW-1:0] quo
);
  localparam int CW = $clog2(NW + 1);

  logic [DW-1:0] rem_q, rem_n;
  logic [DW-1:0] den_q, den_n;
  logic [NW-1:0] quo_q, quo_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          done_q, done_n;
  logic [DW:0]   shifted;
  logic [DW:0]   trial;
  logic          fits;

  always_comb begin
    shifted = {rem_q, quo_q[NW-1]};
    trial   = shifted - {1'b0, den_q};
    fits    = (shifted >= {1'b0, den_q});
    rem_n   = rem_q;
    den_n   = den_q;
    quo_n   = quo_q;
    cnt_n   = cnt_q;
    done_n  = 1'b0;
    if (start) begin
      rem_n = '0;
      den_n = den;
      quo_n = num;
      cnt_n = CW'(NW);
    end else if (cnt_q != '0) begin
      rem_n  = fits ? trial[DW-1:0] : shifted[DW-1:0];
      quo_n  = {quo_q[NW-2:0], fits};
      cnt_n  = cnt_q - 1'b1;
      done_n = (cnt_q == CW'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      den_q  <= '0;
      quo_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      rem_q  <= rem_n;
      den_q  <= den_n;
      quo_q  <= quo_n;
      cnt_q  <= cnt_n;
      done_q <= done_n;
    end
  end

  assign done = done_q;
  assign quo  = quo_q;
endmodule

// File: rtl/pllsrch_sweep.sv
module pllsrch_sweep
  import pllsrch_pkg::*;
#(
  parameter int M_MIN  = 2,
  parameter int M_MAX  = 255,
  parameter int N_MIN  = 2,
  parameter int N_MAX  = 127,
  parameter int K_MAX  = 1,
  parameter int SH_MAX = 7,
  localparam int SH_W  = $clog2(SH_MAX + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            init,
  input  logic            step,
  input  logic [DV_W-1:0] max_div,
  output logic [M_W-1:0]  m,
  output logic [N_W-1:0]  n,
  output logic            k,
  output logic [DV_W-1:0] dv,
  output logic [SH_W-1:0] sh,
  output logic            src_wrap,
  output logic            sweep_last
);
  logic [M_W-1:0]  m_q, m_n;
  logic [N_W-1:0]  n_q, n_n;
  logic            k_q, k_n;
  logic [DV_W-1:0] dv_q, dv_n, md_q, md_n;
  logic [SH_W-1:0] sh_q, sh_n;
  logic sh_last, dv_last, k_last, n_last, m_last;

  always_comb begin
    sh_last    = (sh_q == SH_W'(SH_MAX));
    dv_last    = ({1'b0, dv_q} + 4'd2) > {1'b0, md_q};
    k_last     = (k_q == 1'(K_MAX));
    n_last     = (n_q == N_W'(N_MAX));
    m_last     = (m_q == M_W'(M_MAX));
    src_wrap   = sh_last && dv_last && k_last;
    sweep_last = src_wrap && n_last && m_last;

    m_n = m_q; n_n = n_q; k_n = k_q; dv_n = dv_q; sh_n = sh_q; md_n = md_q;
    if (init) begin
      m_n  = M_W'(M_MIN);
      n_n  = N_W'(N_MIN);
      k_n  = 1'b0;
      dv_n = DV_W'(1);
      sh_n = '0;
      md_n = max_div;
    end else if (step && !sweep_last) begin
      if (!sh_last) begin
        sh_n = sh_q + 1'b1;
      end else begin
        sh_n = '0;
        if (!dv_last) begin
          dv_n = dv_q + DV_W'(2);
        end else begin
          dv_n = DV_W'(1);
          if (!k_last) begin
            k_n = 1'b1;
          end else begin
            k_n = 1'b0;
            if (!n_last) begin
              n_n = n_q + 1'b1;
            end else begin
              n_n = N_W'(N_MIN);
              m_n = m_q + 1'b1;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q <= '0; n_q <= '0; k_q <= 1'b0; dv_q <= '0; sh_q <= '0; md_q <= '0;
    end else begin
      m_q <= m_n; n_q <= n_n; k_q <= k_n; dv_q <= dv_n; sh_q <= sh_n; md_q <= md_n;
    end
  end

  assign m  = m_q;
  assign n  = n_q;
  assign k  = k_q;
  assign dv = dv_q;
  assign sh = sh_q;
endmodule

// File: rtl/pllsrch_best.sv
module pllsrch_best
  import pllsrch_pkg::*;
#(
  parameter int NW   = 34,
  parameter int EW   = 35,
  parameter int SH_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            cand_valid,
  input  logic [NW-1:0]   cand,
  input  logic [EW-1:0]   req,
  input  logic [NW-1:0]   src,
  input  logic [M_W-1:0]  m,
  input  logic [N_W-1:0]  n,
  input  logic            k,
  input  logic [DV_W-1:0] dv,
  input  logic [SH_W-1:0] sh,
  output logic [M_W-1:0]  best_m,
  output logic [N_W-1:0]  best_n,
  output logic            best_k,
  output logic [DV_W-1:0] best_dv,
  output logic [SH_W-1:0] best_sh,
  output logic [NW-1:0]   best_src,
  output logic [EW-1:0]   best_err
);
  localparam logic [EW-1:0] ERR_INIT = EW'(999_999_999);

  logic [EW-1:0]   cand_e, err;
  logic            better;
  logic [M_W-1:0]  m_q, m_n;
  logic [N_W-1:0]  n_q, n_n;
  logic            k_q, k_n;
  logic [DV_W-1:0] dv_q, dv_n;
  logic [SH_W-1:0] sh_q, sh_n;
  logic [NW-1:0]   src_q, src_n;
  logic [EW-1:0]   err_q, err_n;

  always_comb begin
    cand_e = EW'(cand);
    err    = (cand_e >= req) ? (cand_e - req) : (req - cand_e);
    better = cand_valid && (err < err_q);
    m_n = m_q; n_n = n_q; k_n = k_q; dv_n = dv_q; sh_n = sh_q;
    src_n = src_q; err_n = err_q;
    if (clear) begin
      m_n = '0; n_n = '0; k_n = 1'b0; dv_n = '0; sh_n = '0;
      src_n = '0; err_n = ERR_INIT;
    end else if (better) begin
      m_n = m; n_n = n; k_n = k; dv_n = dv; sh_n = sh;
      src_n = src; err_n = err;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q <= '0; n_q <= '0; k_q <= 1'b0; dv_q <= '0; sh_q <= '0;
      src_q <= '0; err_q <= ERR_INIT;
    end else begin
      m_q <= m_n; n_q <= n_n; k_q <= k_n; dv_q <= dv_n; sh_q <= sh_n;
      src_q <= src_n; err_q <= err_n;
    end
  end

  assign best_m   = m_q;
  assign best_n   = n_q;
  assign best_k   = k_q;
  assign best_dv  = dv_q;
  assign best_sh  = sh_q;
  assign best_src = src_q;
  assign best_err = err_q;
endmodule

// File: rtl/pllsrch_engine.sv
module pllsrch_engine
  import pllsrch_pkg::*;
#(
  parameter longint REF_HZ = 24_000_000,
  parameter int M_MIN  = 2,
  parameter int M_MAX  = 255,
  parameter int N_MIN  = 2,
  parameter int N_MAX  = 127,
  parameter int K_MAX  = 1,
  parameter int SH_MAX = 7,
  parameter int FW     = 32,
  localparam int SH_W  = $clog2(SH_MAX + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [FW-1:0]   req_freq,
  input  logic [DV_W-1:0] max_div,
  output logic            busy,
  output logic            done,
  output logic [M_W-1:0]  m_out,
  output logic [N_W-1:0]  n_out,
  output logic            k_out,
  output logic [DV_W-1:0] div_out,
  output logic [SH_W-1:0] shift_out,
  output logic [FW-1:0]   achieved_freq,
  output logic [31:0]     pll_word
);
  localparam int NW    = $clog2(REF_HZ * M_MAX) + 1;
  localparam int EW    = ((NW > FW) ? NW : FW) + 1;
  localparam int DEN_W = DV_W + SH_MAX + 1;

  logic            rst_q;
  phase_t          st_q, st_n;
  logic [FW-1:0]   req_q, req_n;
  logic [NW-1:0]   qmn_q, qmn_n;
  logic [FW-1:0]   ach_q, ach_n;
  logic            done_q, done_n;

  logic            sw_init, sw_step, sw_wrap, sw_last;
  logic            best_clr, cand_vld;
  logic [M_W-1:0]  cur_m;
  logic [N_W-1:0]  cur_n;
  logic            cur_k;
  logic [DV_W-1:0] cur_dv;
  logic [SH_W-1:0] cur_sh;
  logic [M_W-1:0]  best_m;
  logic [N_W-1:0]  best_n;
  logic            best_k;
  logic [DV_W-1:0] best_dv;
  logic [SH_W-1:0] best_sh;
  logic [NW-1:0]   best_src;
  logic [EW-1:0]   best_err;

  logic            div_go, div_done;
  logic [NW-1:0]   div_num, div_quo;
  logic [DEN_W-1:0] div_den;
  logic [NW-1:0]   src_cur;
  logic [DEN_W-1:0] den_cand, den_best;

  pllsrch_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_q));

  pllsrch_sweep #(
    .M_MIN(M_MIN), .M_MAX(M_MAX), .N_MIN(N_MIN), .N_MAX(N_MAX),
    .K_MAX(K_MAX), .SH_MAX(SH_MAX)
  ) u_sweep (
    .clk(clk), .rst_n(rst_q), .init(sw_init), .step(sw_step), .max_div(max_div),
    .m(cur_m), .n(cur_n), .k(cur_k), .dv(cur_dv), .sh(cur_sh),
    .src_wrap(sw_wrap), .sweep_last(sw_last)
  );

  pllsrch_div #(.NW(NW), .DW(DEN_W)) u_div (
    .clk(clk), .rst_n(rst_q), .start(div_go), .num(div_num), .den(div_den),
    .done(div_done), .quo(div_quo)
  );

  pllsrch_best #(.NW(NW), .EW(EW), .SH_W(SH_W)) u_best (
    .clk(clk), .rst_n(rst_q), .clear(best_clr), .cand_valid(cand_vld),
    .cand(div_quo), .req(EW'(req_q)), .src(src_cur),
    .m(cur_m), .n(cur_n), .k(cur_k), .dv(cur_dv), .sh(cur_sh),
    .best_m(best_m), .best_n(best_n), .best_k(best_k), .best_dv(best_dv),
    .best_sh(best_sh), .best_src(best_src), .best_err(best_err)
  );

  // Divider operand selection by phase.
  always_comb begin
    src_cur  = qmn_q >> cur_k;
    den_cand = DEN_W'(cur_dv) << cur_sh;
    den_best = (DEN_W'(best_dv) << best_sh) << 1;
    div_num  = '0;
    div_den  = '0;
    case (st_q)
      ST_SRC:  begin div_num = NW'(REF_HZ * cur_m);                div_den = DEN_W'(cur_n); end
      ST_CAND: begin div_num = src_cur + NW'(den_cand >> 1);       div_den = den_cand;      end
      ST_FIN:  begin div_num = best_src;                            div_den = den_best;      end
      default: ;
    endcase
  end

  // Sequencer next state.
  always_comb begin
    st_n = st_q; req_n = req_q; qmn_n = qmn_q; ach_n = ach_q; done_n = 1'b0;
    sw_init = 1'b0; sw_step = 1'b0; best_clr = 1'b0; cand_vld = 1'b0; div_go = 1'b0;
    case (st_q)
      ST_IDLE: if (start) begin
        st_n = ST_SRC; req_n = req_freq; sw_init = 1'b1; best_clr = 1'b1;
      end
      ST_SRC:  begin div_go = 1'b1; st_n = ST_SRCW; end
      ST_SRCW: if (div_done) begin qmn_n = div_quo; st_n = ST_CAND; end
      ST_CAND: begin div_go = 1'b1; st_n = ST_CANDW; end
      ST_CANDW: if (div_done) begin
        cand_vld = 1'b1;
        sw_step  = 1'b1;
        if (sw_last)      st_n = ST_FIN;
        else if (sw_wrap) st_n = ST_SRC;
        else              st_n = ST_CAND;
      end
      ST_FIN: if (best_dv == '0) begin
        ach_n = '0; done_n = 1'b1; st_n = ST_IDLE;
      end else begin
        div_go = 1'b1; st_n = ST_FINW;
      end
      ST_FINW: if (div_done) begin
        ach_n = FW'(div_quo); done_n = 1'b1; st_n = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      st_q   <= ST_IDLE;
      req_q  <= '0;
      qmn_q  <= '0;
      ach_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      req_q  <= req_n;
      qmn_q  <= qmn_n;
      ach_q  <= ach_n;
      done_q <= done_n;
    end
  end

  assign busy          = (st_q != ST_IDLE);
  assign done          = done_q;
  assign m_out         = best_m;
  assign n_out         = best_n;
  assign k_out         = best_k;
  assign div_out       = best_dv;
  assign shift_out     = best_sh;
  assign achieved_freq = ach_q;
  assign pll_word      = pack_word(best_k, best_n, best_m);
endmodule

// File: rtl/pllsrch_checker.sv
module pllsrch_checker #(
  parameter int M_MIN  = 2,
  parameter int M_MAX  = 255,
  parameter int SH_MAX = 7,
  parameter int FW     = 32,
  parameter int EW     = 35,
  parameter int SH_W   = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic [FW-1:0]   achieved_freq,
  input logic [EW-1:0]   best_err,
  input logic [7:0]      cur_m,
  input logic [2:0]      cur_dv,
  input logic [SH_W-1:0] cur_sh
);
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r8_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  a_r7_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(achieved_freq));

  a_r4_err_nonincreasing: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (best_err <= $past(best_err)));

  a_r3_m_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cur_m >= 8'(M_MIN) && cur_m <= 8'(M_MAX)));

  a_r3_div_odd: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cur_dv[0]);

  a_r3_shift_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cur_sh <= SH_W'(SH_MAX)));
endmodule

bind pllsrch_engine pllsrch_checker #(
  .M_MIN(M_MIN), .M_MAX(M_MAX), .SH_MAX(SH_MAX), .FW(FW), .EW(EW), .SH_W(SH_W)
) u_chk (
  .clk(clk), .rst_n(rst_q), .start(start), .busy(busy), .done(done),
  .achieved_freq(achieved_freq), .best_err(best_err),
  .cur_m(cur_m), .cur_dv(cur_dv), .cur_sh(cur_sh)
);

// File: tb/pllsrch_engine_test.sv
module pllsrch_engine_test;
  localparam longint REF = 24_000_000;
  localparam int MLO = 2, MHI = 4, NLO = 2, NHI = 3;

  logic        clk, rst_n, start;
  logic [31:0] req_freq;
  logic [2:0]  max_div;
  logic        busy, done, k_out;
  logic [7:0]  m_out;
  logic [6:0]  n_out;
  logic [2:0]  div_out, shift_out;
  logic [31:0] achieved_freq, pll_word;

  int checks = 0;
  int errors = 0;

  pllsrch_engine #(.M_MIN(MLO), .M_MAX(MHI), .N_MIN(NLO), .N_MAX(NHI)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .req_freq(req_freq), .max_div(max_div),
    .busy(busy), .done(done), .m_out(m_out), .n_out(n_out), .k_out(k_out),
    .div_out(div_out), .shift_out(shift_out), .achieved_freq(achieved_freq),
    .pll_word(pll_word)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Arithmetic optimum of the search (R2, R3, R4, R5, R7).
  task automatic model(input longint req, input int md,
                       output int bm, output int bn, output int bk,
                       output int bd, output int bs, output longint ach);
    longint best = 999_999_999;
    longint bsrc = 0;
    bm = 0; bn = 0; bk = 0; bd = 0; bs = 0;
    for (int m = MLO; m <= MHI; m++)
      for (int n = NLO; n <= NHI; n++)
        for (int k = 0; k <= 1; k++) begin
          longint src = (REF * m / n) >> k;
          for (int d = 1; d == 1 || d <= md; d += 2)
            for (int s = 0; s <= 7; s++) begin
              longint den = longint'(d) << s;
              longint c = (src + den / 2) / den;
              longint e = (c >= req) ? c - req : req - c;
              if (e < best) begin
                best = e; bsrc = src; bm = m; bn = n; bk = k; bd = d; bs = s;
              end
            end
        end
    ach = (bd == 0) ? 0 : bsrc / (2 * (longint'(bd) << bs));
  endtask

  task automatic run(input longint req, input int md, input bit disturb);
    int bm, bn, bk, bd, bs;
    longint ach, word;
    int waited = 0;
    model(req, md, bm, bn, bk, bd, bs, ach);
    word = 64'h20000 | (longint'(bk) << 15) | (longint'(bn) << 8) | longint'(bm);
    @(negedge clk);
    start = 1'b1; req_freq = 32'(req); max_div = 3'(md);
    @(negedge clk);
    start = 1'b0;
    chk("R8 busy after start", longint'(busy), 1);
    while (!done) begin
      @(negedge clk);
      waited++;
      if (disturb && waited == 50) begin
        start = 1'b1; req_freq = 32'd777; max_div = 3'd1;
      end
      if (disturb && waited == 51) start = 1'b0;
    end
    chk("R8 busy low at done", longint'(busy), 0);
    chk("R2 R4 chosen M", longint'(m_out), bm);
    chk("R2 R4 chosen N", longint'(n_out), bn);
    chk("R2 R3 chosen K", longint'(k_out), bk);
    chk("R3 chosen divider", longint'(div_out), bd);
    chk("R3 chosen shift", longint'(shift_out), bs);
    chk("R7 achieved freq", longint'(achieved_freq), ach);
    chk("R6 pll word", longint'(pll_word), word);
    if (disturb) chk("R9 capture held through sweep", longint'(m_out), bm);
    @(negedge clk);
    chk("R8 done one cycle", longint'(done), 0);
  endtask

  initial begin
    repeat (195_000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R8 watchdog expired actual=busy expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; req_freq = '0; max_div = 3'd5;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 busy at reset", longint'(busy), 0);
    chk("R1 done at reset", longint'(done), 0);
    chk("R1 achieved at reset", longint'(achieved_freq), 0);
    chk("R1 word at reset", longint'(pll_word), 64'h20000);
    chk("R1 M at reset", longint'(m_out), 0);

    run(12_000_000, 5, 1'b0);   // exact tie among many settings (R4)
    run(10_000_000, 3, 1'b0);
    run(1_234_567, 5, 1'b0);
    run(47_000_000, 5, 1'b0);
    run(100_000, 3, 1'b0);
    run(31_415_926, 5, 1'b1);   // restart and max_div change mid-sweep (R8, R9)
    run(3_000, 5, 1'b0);
    run(64'hFFFF_FFFF, 5, 1'b0); // nothing beats the initial error (R5)

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule